// File: doc/BRIEF.md
# SPI Frame CRC Checker

This block is a 16-bit-word SPI slave with integrity checking in both directions. Each complete word that arrives on the serial input is folded into a running CRC-8. The host closes a block of writes by sending a command word, marked by a fixed upper byte. Its lower byte carries the host's own CRC of the words sent since the last such command. The block compares the two values and then restarts its input accumulator. A mismatch latches an error. Unless the error is masked, the error pulls an active-low fault line. The error also overrides a drive signal with a configured safe level.

In the other direction, every word shifted out on the serial output is folded into a second CRC-8. Each time chip select returns high, the output CRC is copied into a readable register. The host can then compare that register with what it actually received. The register read is reduced to a single strobe, and that strobe restarts the output accumulator. Both CRCs use polynomial 0x07 with initial value 0xFF. Each word is processed with its high byte first and its bits MSB first. There is no reflection and no final XOR.

SCLK, chip select and the serial input are synchronized into the system clock domain. The system clock must therefore run at least four times faster than SCLK.

Top module: `spi_crc_guard`

## Requirements
- R1: SPI mode 0 is used: the serial input is sampled on rising SCLK, MSB first. After each complete non-command 16-bit word, that word appears on `rx_word` and `rx_valid` pulses for one clock.
- R2: The serial output shifts on falling SCLK, MSB first. It presents `sdo_word` as loaded when chip select falls. After each completed word, the next falling SCLK edge loads `sdo_word` again.
- R3: For each complete word whose upper byte is not CMD (default 0xC3), the input CRC becomes crc8(crc8(crc, word[15:8]), word[7:0]). Here crc8 means polynomial 0x07, MSB-first bits, and the start value is 0xFF.
- R4: A word whose upper byte equals CMD compares its lower byte with the input CRC and resets that CRC to 0xFF. The word is left out of the input CRC, and it produces no `rx_valid` pulse.
- R5: A word cut short by chip select rising before the 16th bit changes neither CRC and produces no `rx_valid` pulse.
- R6: Every rising edge of chip select copies the output CRC into `rx_crc`. The output CRC covers every complete word shifted out, command words included.
- R7: A pulse on `rx_crc_rd` resets the output CRC accumulator to 0xFF.
- R8: A compare mismatch sets `crc_err`, and `crc_err` stays set until `err_clr`. `fault_n` is low exactly while `crc_err` is set and `err_mask` is low.
- R9: `drive_out` equals `safe_lvl` while `crc_err` is set, and equals `drive_in` otherwise.
- R10: After reset, `crc_err` is 0, `fault_n` is 1, `rx_crc` is 0xFF and both accumulators hold 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| sdi | input | 1 | SPI serial data in |
| sdo | output | 1 | SPI serial data out (low while deselected) |
| sdo_word | input | 16 | Word to shift out next |
| rx_word | output | 16 | Last received non-command word |
| rx_valid | output | 1 | One-clock pulse when rx_word updates |
| rx_crc_rd | input | 1 | Strobe: receive-CRC register read |
| rx_crc | output | 8 | Output-side CRC latched at chip select rise |
| err_mask | input | 1 | Masks the fault output |
| err_clr | input | 1 | Clears the CRC error |
| drive_in | input | 1 | Normal drive request |
| safe_lvl | input | 1 | Drive level forced on error |
| drive_out | output | 1 | Drive output |
| crc_err | output | 1 | Sticky CRC mismatch status |
| fault_n | output | 1 | Active-low fault |

## Verification
Every SPI edge passes through a two-stage synchronizer and an edge detector before it reaches the register it affects. An SCLK or chip select transition therefore shows up on `sdo`, `rx_word`, `crc_err` or `rx_crc` about four system clocks later. The bench holds each SCLK level for eight clocks and samples the serial output just before raising SCLK. It checks the word, error and fault results six clocks after the final falling edge of a word. It checks `rx_crc` eight clocks after chip select rises. The mask, clear and read strobes act within one clock, and the bench samples them two clocks later.

// File: rtl/spi_crc_guard.sv
module spi_crc_guard #(
  parameter logic [7:0] CMD = 8'hC3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        sdi,
  output logic        sdo,
  input  logic [15:0] sdo_word,
  output logic [15:0] rx_word,
  output logic        rx_valid,
  input  logic        rx_crc_rd,
  output logic [7:0]  rx_crc,
  input  logic        err_mask,
  input  logic        err_clr,
  input  logic        drive_in,
  input  logic        safe_lvl,
  output logic        drive_out,
  output logic        crc_err,
  output logic        fault_n
);
  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] crc16w(input logic [7:0] c, input logic [15:0] w);
    return crc8(crc8(c, w[15:8]), w[7:0]);
  endfunction

  logic [2:0]  sck_s, cs_s;
  logic [1:0]  sdi_s;
  logic [3:0]  cnt;
  logic [14:0] sh_in;
  logic [15:0] sh_out, out_word;
  logic        reload;
  logic [7:0]  sdi_crc, sdo_crc;

  wire sck_rise  = sck_s[1] & ~sck_s[2];
  wire sck_fall  = ~sck_s[1] & sck_s[2];
  wire sel       = ~cs_s[1];
  wire cs_fall   = ~cs_s[1] & cs_s[2];
  wire cs_rise   = cs_s[1] & ~cs_s[2];
  wire [15:0] in_word = {sh_in, sdi_s[1]};
  wire word_done = sel & sck_rise & (cnt == 4'd15);
  wire is_cmd    = in_word[15:8] == CMD;
  wire mismatch  = word_done & is_cmd & (in_word[7:0] != sdi_crc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      cs_s  <= '1;
      sdi_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sclk};
      cs_s  <= {cs_s[1:0], cs_n};
      sdi_s <= {sdi_s[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sh_in <= '0;
    end else begin
      if (!sel) cnt <= '0;
      else if (sck_rise) cnt <= cnt + 4'd1;
      if (sel && sck_rise) sh_in <= in_word[14:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_out   <= '0;
      out_word <= '0;
      reload   <= 1'b0;
    end else if (cs_fall) begin
      sh_out   <= sdo_word;
      out_word <= sdo_word;
      reload   <= 1'b0;
    end else begin
      if (sel && sck_fall) begin
        if (reload) begin
          sh_out   <= sdo_word;
          out_word <= sdo_word;
          reload   <= 1'b0;
        end else begin
          sh_out <= {sh_out[14:0], 1'b0};
        end
      end
      if (word_done) reload <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word  <= '0;
      rx_valid <= 1'b0;
      sdi_crc  <= 8'hFF;
      sdo_crc  <= 8'hFF;
      rx_crc   <= 8'hFF;
      crc_err  <= 1'b0;
    end else begin
      rx_valid <= word_done & ~is_cmd;
      if (word_done && !is_cmd) rx_word <= in_word;
      if (word_done) sdi_crc <= is_cmd ? 8'hFF : crc16w(sdi_crc, in_word);
      if (rx_crc_rd) sdo_crc <= 8'hFF;
      else if (word_done) sdo_crc <= crc16w(sdo_crc, out_word);
      if (cs_rise) rx_crc <= sdo_crc;
      if (mismatch) crc_err <= 1'b1;
      else if (err_clr) crc_err <= 1'b0;
    end
  end

  assign sdo       = sel & sh_out[15];
  assign fault_n   = ~(crc_err & ~err_mask);
  assign drive_out = crc_err ? safe_lvl : drive_in;

  // R5
  bit_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> cnt == 4'd0);
  // R3
  sdi_crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> $stable(sdi_crc));
  // R4
  cmd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && is_cmd) |=> sdi_crc == 8'hFF && !rx_valid);
  // R6
  rx_crc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> rx_crc == $past(sdo_crc));
  // R7
  sdo_crc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_crc_rd |=> sdo_crc == 8'hFF);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !err_clr) |=> crc_err);
endmodule

// File: tb/sim_spi_crc_guard.sv
`timescale 1ns/1ps
module sim_spi_crc_guard;
  localparam logic [7:0] CMD = 8'hC3;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, sdi = 0;
  logic [15:0] sdo_word = 0;
  logic rx_crc_rd = 0, err_mask = 0, err_clr = 0, drive_in = 0, safe_lvl = 1;
  logic sdo, rx_valid, drive_out, crc_err, fault_n;
  logic [15:0] rx_word;
  logic [7:0] rx_crc;

  int checks = 0, fails = 0, nvalid = 0;
  logic [7:0] m_sdi = 8'hFF, m_sdo = 8'hFF;
  logic m_err = 0;

  always #5 clk = ~clk;

  spi_crc_guard #(.CMD(CMD)) u0 (.*);

  always @(posedge clk) if (rst_n && rx_valid) nvalid++;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction
  function automatic logic [7:0] crcw(input logic [7:0] c, input logic [15:0] w);
    return crc8(crc8(c, w[15:8]), w[7:0]);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cs_low(input logic [15:0] first);
    sdo_word = first;
    cs_n = 0;
    tick(HALF);
  endtask

  task automatic cs_high();
    tick(HALF);
    cs_n = 1;
    tick(HALF);
    chk(rx_crc == m_sdo, "R6 rx_crc", rx_crc, m_sdo);
  endtask

  task automatic xfer(input logic [15:0] din, input logic [15:0] dout, input logic [15:0] nxt);
    logic [15:0] got;
    int nv;
    nv = nvalid;
    for (int i = 15; i >= 0; i--) begin
      sdi = din[i];
      tick(HALF);
      got[i] = sdo;
      sclk = 1;
      if (i == 0) sdo_word = nxt;
      tick(HALF);
      sclk = 0;
    end
    tick(6);
    chk(got == dout, "R2 sdo word", got, dout);
    m_sdo = crcw(m_sdo, dout);
    if (din[15:8] == CMD) begin
      if (din[7:0] != m_sdi) m_err = 1;
      m_sdi = 8'hFF;
      chk(nvalid == nv, "R4 no rx_valid on command", nvalid - nv, 0);
      chk(crc_err == m_err, "R4 compare result", crc_err, m_err);
    end else begin
      m_sdi = crcw(m_sdi, din);
      chk(rx_word == din && nvalid == nv + 1, "R1 rx_word", rx_word, din);
    end
  endtask

  function automatic logic [15:0] rnd_word();
    logic [15:0] w = 16'($urandom());
    if (w[15:8] == CMD) w[15] = ~w[15];
    return w;
  endfunction

  task automatic clear_err();
    err_clr = 1; tick(1); err_clr = 0; m_err = 0; tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] a, b, c;
    void'($urandom(32'h1234));
    tick(3);
    rst_n = 1;
    tick(2);
    // R10
    chk(crc_err == 0 && fault_n == 1, "R10 status", {crc_err, fault_n}, 2'b01);
    chk(rx_crc == 8'hFF, "R10 rx_crc", rx_crc, 8'hFF);
    chk(sdo == 0, "R10 sdo idle", sdo, 0);

    // R1 R2 R3 R6: several words, then a correct CRC command
    a = rnd_word(); b = rnd_word(); c = rnd_word();
    cs_low(a);
    xfer(16'hA55A, a, b);
    xfer(16'h0001, b, c);
    xfer({CMD, crcw(crcw(8'hFF, 16'hA55A), 16'h0001)}, c, 16'h8001);
    cs_high();
    chk(crc_err == 0, "R3 matched crc", crc_err, 0);

    // R4: accumulator restarted after the compare
    cs_low(16'hFFFF);
    xfer(16'h1234, 16'hFFFF, 16'h0000);
    xfer({CMD, crcw(8'hFF, 16'h1234)}, 16'h0000, 16'h0);
    cs_high();
    chk(crc_err == 0, "R4 restart after compare", crc_err, 0);

    // R8 R9: mismatch
    drive_in = 0; safe_lvl = 1;
    cs_low(16'h5555);
    xfer(16'h7777, 16'h5555, 16'hAAAA);
    xfer({CMD, ~crcw(8'hFF, 16'h7777)}, 16'hAAAA, 16'h0);
    cs_high();
    chk(crc_err == 1 && fault_n == 0, "R8 error and fault", {crc_err, fault_n}, 2'b10);
    chk(drive_out == 1, "R9 forced drive", drive_out, 1);
    safe_lvl = 0; drive_in = 1; tick(1);
    chk(drive_out == 0, "R9 forced low", drive_out, 0);
    err_mask = 1; tick(2);
    chk(fault_n == 1 && crc_err == 1, "R8 masked", {crc_err, fault_n}, 2'b11);
    err_mask = 0;
    tick(20);
    chk(crc_err == 1, "R8 sticky", crc_err, 1);
    clear_err();
    chk(crc_err == 0 && fault_n == 1 && drive_out == 1, "R8 R9 cleared",
        {crc_err, fault_n, drive_out}, 3'b011);

    // R5: aborted word
    begin
      int nv;
      logic [7:0] keep;
      nv = nvalid;
      keep = m_sdo;
      cs_low(16'hF0F0);
      for (int i = 0; i < 7; i++) begin
        sdi = i[0]; tick(HALF); sclk = 1; tick(HALF); sclk = 0;
      end
      cs_high();
      chk(nvalid == nv, "R5 no rx_valid on abort", nvalid - nv, 0);
      chk(rx_crc == keep, "R5 sdo crc untouched", rx_crc, keep);
      cs_low(16'h0F0F);
      xfer({CMD, m_sdi}, 16'h0F0F, 16'h0);
      cs_high();
      chk(crc_err == 0, "R5 sdi crc untouched", crc_err, 0);
    end

    // R7: read strobe restarts output accumulator
    rx_crc_rd = 1; tick(1); rx_crc_rd = 0; m_sdo = 8'hFF; tick(1);
    cs_low(16'hBEEF);
    xfer(16'h4242, 16'hBEEF, 16'h0);
    cs_high();
    chk(rx_crc == crcw(8'hFF, 16'hBEEF), "R7 restart", rx_crc, crcw(8'hFF, 16'hBEEF));

    // random sessions
    for (int s = 0; s < 8; s++) begin
      int n;
      logic [15:0] cur, nx;
      n = 1 + ($urandom() % 4);
      cur = 16'($urandom());
      cs_low(cur);
      for (int k = 0; k < n; k++) begin
        nx = 16'($urandom());
        xfer(rnd_word(), cur, nx);
        cur = nx;
      end
      nx = 16'($urandom());
      xfer({CMD, ($urandom() % 3 == 0) ? ~m_sdi : m_sdi}, cur, nx);
      cs_high();
      chk(fault_n == ~m_err, "R8 random fault", fault_n, ~m_err);
      if (m_err) clear_err();
      if (s[0]) begin
        rx_crc_rd = 1; tick(1); rx_crc_rd = 0; m_sdo = 8'hFF; tick(1);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule